// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor that fetches, decodes, executes and retires one instruction in every clock period. Program and data sit in two separate memories outside the core. The core drives a word address to the program memory and receives the instruction word back combinationally. On the data side it drives an address, a write value and a write strobe, and it receives a read value combinationally. A store commits at the rising clock edge at the end of the cycle that executes it.

The instruction set has eight operations: word load, word store, branch-if-equal, and the register-to-register operations add, subtract, bitwise AND, bitwise OR and signed set-less-than. Every other encoding retires as a no-op. The core holds the program counter, a 32-entry register file whose entry zero is constant zero, a 16-to-32-bit sign extender, the ALU operand and write-back selectors and the branch target adder. A trace output gives, in every cycle out of reset, the address of the instruction that retires at the next clock edge.

Top module: `mini_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0x00000000. `dmem_we` stays 0 and no register is written during any reset cycle.
- R2: `imem_addr` equals the program counter. Any instruction other than a taken branch advances the program counter by 4.
- R3: The register-format instruction has opcode bits [31:26] = 000000 and fields rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. It writes rd with one of rs+rt (funct 100000), rs-rt (100010), rs AND rt (100100), rs OR rt (100101), or, for funct 101010, 1 when rs < rt as signed numbers and 0 otherwise.
- R4: The load has opcode 100011 and an immediate in [15:0]. It reads data memory at rs plus the sign-extended immediate and writes the returned word to register rt.
- R5: The store has opcode 101011. It drives `dmem_addr` = rs plus the sign-extended immediate, `dmem_wdata` = rt and `dmem_we` = 1, and it writes no register.
- R6: The branch has opcode 000100. When rs equals rt, the next program counter is PC+4 plus the sign-extended immediate shifted left by two, and a negative immediate branches backwards. When they differ, the next program counter is PC+4.
- R7: Register 0 always reads as zero. A write aimed at it is discarded.
- R8: Any opcode outside the four above, and any register-format funct outside the five above, writes neither register nor memory, and the program counter advances by 4.
- R9: `trace_valid` is 1 in every cycle in which `rst` is low and 0 while it is high. `trace_pc` carries the address of the instruction retiring in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Value to store |
| dmem_we | output | 1 | Store strobe, committed at the rising edge |
| dmem_rdata | input | 32 | Word read at `dmem_addr` |
| trace_valid | output | 1 | An instruction retires this cycle |
| trace_pc | output | 32 | Address of the retiring instruction |

## Verification
Assertions check the following in every cycle: program counter sequencing and the branch target, the store strobe and store value, load write-back to rt, the no-op handling of unlisted encodings, reading zero from register 0, and the agreement of the trace output with the fetch address. The numeric results of the ALU operations, including signed set-less-than on mixed-sign operands, and the fact that a discarded write to register 0 leaves it at zero, can only be shown by running a program. For that, the bench stores registers to memory and compares each store against the expected value. The same program shows that a taken branch skips the stores behind it, and that a reset in the middle of a run sends fetch back to address zero.

// File: rtl/mini_core_pkg.sv
package mini_core_pkg;

    localparam int XLEN     = 32;
    localparam int ILEN     = 32;
    localparam int REG_AW   = 5;
    localparam int NUM_REGS = 2 ** REG_AW;
    localparam int IMM_W    = 16;
    localparam int OPC_W    = 6;
    localparam int FN_W     = 6;
    localparam int PC_STEP  = ILEN / 8;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [FN_W-1:0]   funct;
        logic [IMM_W-1:0]  imm;
    } instr_fields_t;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    src_b_imm;
        logic    wb_from_mem;
        logic    mem_we;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        reg_we: 1'b0, dst_is_rd: 1'b0, src_b_imm: 1'b0, wb_from_mem: 1'b0,
        mem_we: 1'b0, is_branch: 1'b0, alu_op: ALU_ADD
    };

    function automatic instr_fields_t split_instr(input logic [ILEN-1:0] w);
        instr_fields_t f;
        f.opcode = w[31:26];
        f.rs     = w[25:21];
        f.rt     = w[20:16];
        f.rd     = w[15:11];
        f.funct  = w[5:0];
        f.imm    = w[15:0];
        return f;
    endfunction

    function automatic logic [XLEN-1:0] sign_ext(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mini_core_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output ctrl_t            ctrl
);

    always_comb begin
        ctrl = CTRL_NOP;
        unique case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_we      = 1'b1;
                ctrl.src_b_imm   = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.alu_op      = ALU_ADD;
            end
            OPC_STORE: begin
                ctrl.mem_we    = 1'b1;
                ctrl.src_b_imm = 1'b1;
                ctrl.alu_op    = ALU_ADD;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ctrl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mini_core_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int W     = XLEN
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(NREGS)-1:0] raddr_a,
    input  logic [$clog2(NREGS)-1:0] raddr_b,
    output logic [W-1:0]             rdata_a,
    output logic [W-1:0]             rdata_b
);

    localparam int AW = $clog2(NREGS);

    logic [W-1:0] regs [1:NREGS-1];

    for (genvar i = 1; i < NREGS; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
    end

    // R7: entry zero reads as zero even right after a write aimed at it
    p_zero_after_write_r7: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr == '0) && (raddr_a == '0)) |-> (rdata_a == '0));

    // R3/R4: a written entry returns the written value on the next read of it
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr != '0) && (raddr_a == waddr)) |=>
            ((raddr_a != $past(waddr)) || (rdata_a == $past(wdata))));

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mini_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  alu_op_e      op,
    output logic [W-1:0] result,
    output logic         is_zero
);

    logic [W-1:0] diff;

    always_comb begin
        diff = src_a - src_b;
        unique case (op)
            ALU_ADD: result = src_a + src_b;
            ALU_SUB: result = diff;
            ALU_AND: result = src_a & src_b;
            ALU_OR:  result = src_a | src_b;
            ALU_SLT: result = {{(W-1){1'b0}}, ($signed(src_a) < $signed(src_b))};
            default: result = '0;
        endcase
        is_zero = (diff == '0);
    end

endmodule

// File: rtl/mini_core.sv
module mini_core
    import mini_core_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata,
    output logic        trace_valid,
    output logic [31:0] trace_pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc_plus;
    logic [XLEN-1:0] br_target;
    instr_fields_t   fld;
    ctrl_t           ctrl;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] src_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic            br_taken;
    logic            rf_we;
    logic [REG_AW-1:0] rf_waddr;
    logic [XLEN-1:0] rf_wdata;
    logic            rst_q;

    assign fld     = split_instr(imem_rdata);
    assign imm_ext = sign_ext(fld.imm);

    mc_decode u_decode (
        .opcode (fld.opcode),
        .funct  (fld.funct),
        .ctrl   (ctrl)
    );

    mc_regfile #(.NREGS(NUM_REGS), .W(XLEN)) u_regfile (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (fld.rs),
        .raddr_b (fld.rt),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign src_b = ctrl.src_b_imm ? imm_ext : rt_val;

    mc_alu #(.W(XLEN)) u_alu (
        .src_a   (rs_val),
        .src_b   (src_b),
        .op      (ctrl.alu_op),
        .result  (alu_y),
        .is_zero (alu_zero)
    );

    always_comb begin
        pc_plus   = pc + STEP;
        br_target = pc_plus + {imm_ext[XLEN-3:0], 2'b00};
        br_taken  = ctrl.is_branch && alu_zero;
        pc_next   = br_taken ? br_target : pc_plus;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= RESET_PC;
        end else begin
            pc <= pc_next;
        end
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    always_comb begin
        rf_we    = ctrl.reg_we && !rst;
        rf_waddr = ctrl.dst_is_rd ? fld.rd : fld.rt;
        rf_wdata = ctrl.wb_from_mem ? dmem_rdata : alu_y;
    end

    assign imem_addr   = pc;
    assign dmem_addr   = alu_y;
    assign dmem_wdata  = rt_val;
    assign dmem_we     = ctrl.mem_we && !rst;
    assign trace_valid = !rst;
    assign trace_pc    = pc;

    // R1: the edge after a reset cycle leaves the program counter at the reset address
    always_comb begin
        if (rst_q === 1'b1) begin
            p_reset_pc_r1: assert (pc == RESET_PC);
        end
    end

    // R2: non-branch instructions step the fetch address by one word
    p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] != OPC_BEQ) |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R6: equal operands on a branch redirect to PC+4 plus the scaled offset
    p_beq_target_r6: assert property (@(posedge clk) disable iff (rst)
        ((imem_rdata[31:26] == OPC_BEQ) && (rs_val == rt_val)) |=>
            (imem_addr == $past(imem_addr) + 32'd4
                + $past({{14{imem_rdata[15]}}, imem_rdata[15:0], 2'b00})));

    // R5: a store drives the strobe, the rt value, and writes no register
    p_store_drive_r5: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] == OPC_STORE) |-> (dmem_we && (dmem_wdata == rt_val) && !rf_we));

    // R4: a load writes the returned word into rt
    p_load_wb_r4: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] == OPC_LOAD) |->
            (rf_we && (rf_waddr == imem_rdata[20:16]) && (rf_wdata == dmem_rdata) && !dmem_we));

    // R8: unlisted opcodes leave registers and memory alone
    p_unknown_nop_r8: assert property (@(posedge clk) disable iff (rst)
        ((imem_rdata[31:26] != OPC_REG) && (imem_rdata[31:26] != OPC_LOAD)
         && (imem_rdata[31:26] != OPC_STORE) && (imem_rdata[31:26] != OPC_BEQ))
            |-> (!rf_we && !dmem_we));

    // R9: trace follows the fetch address while running
    p_trace_r9: assert property (@(posedge clk) disable iff (rst)
        trace_valid && (trace_pc == imem_addr));

endmodule

// File: tb/mini_core_bench.sv
module mini_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;
    logic        trace_valid;
    logic [31:0] trace_pc;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    typedef struct {
        logic [31:0] pc;
        string       tag;
    } trace_item_t;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } store_item_t;

    trace_item_t trace_q[$];
    store_item_t store_q[$];

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit running  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles++;

    mini_core u_mini_core (
        .clk         (clk),
        .rst         (rst),
        .imem_addr   (imem_addr),
        .imem_rdata  (imem_rdata),
        .dmem_addr   (dmem_addr),
        .dmem_wdata  (dmem_wdata),
        .dmem_we     (dmem_we),
        .dmem_rdata  (dmem_rdata),
        .trace_valid (trace_valid),
        .trace_pc    (trace_pc)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                          input int rt, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic push_trace(input logic [31:0] pc, input string tag);
        trace_item_t t;
        t.pc  = pc;
        t.tag = tag;
        trace_q.push_back(t);
    endtask

    task automatic push_store(input logic [31:0] addr, input logic [31:0] data,
                              input string tag);
        store_item_t s;
        s.addr = addr;
        s.data = data;
        s.tag  = tag;
        store_q.push_back(s);
    endtask

    // Monitor: compare retirements and stores against the scoreboard queues
    always @(negedge clk) begin
        if (running && !rst) begin
            if (trace_q.size() != 0) begin
                trace_item_t t;
                t = trace_q.pop_front();
                check(trace_valid && (trace_pc == t.pc), t.tag,
                      {31'b0, trace_valid, trace_pc}, {32'd1, t.pc});
            end
            if (dmem_we) begin
                if (store_q.size() == 0) begin
                    check(1'b0, "R6 R8 unexpected store", {dmem_addr, dmem_wdata}, 64'd0);
                end else begin
                    store_item_t s;
                    s = store_q.pop_front();
                    check((dmem_addr == s.addr) && (dmem_wdata == s.data), s.tag,
                          {dmem_addr, dmem_wdata}, {s.addr, s.data});
                end
            end
        end
    end

    localparam logic [5:0] LW  = 6'b100011;
    localparam logic [5:0] SW  = 6'b101011;
    localparam logic [5:0] BEQ = 6'b000100;
    localparam logic [5:0] ADD = 6'b100000;
    localparam logic [5:0] SUB = 6'b100010;
    localparam logic [5:0] AND = 6'b100100;
    localparam logic [5:0] OR  = 6'b100101;
    localparam logic [5:0] SLT = 6'b101010;

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'hFFFF_FFFF;
            dmem[i] = 32'h0;
        end
        dmem[0] = 32'd5;
        dmem[1] = 32'hFFFF_FFFD;
        dmem[2] = 32'h0000_0100;

        imem[0]  = enc_i(LW, 0, 1, 0);
        imem[1]  = enc_i(LW, 0, 2, 4);
        imem[2]  = enc_r(1, 2, 3, ADD);
        imem[3]  = enc_r(1, 2, 4, SUB);
        imem[4]  = enc_r(1, 2, 5, AND);
        imem[5]  = enc_r(1, 2, 6, OR);
        imem[6]  = enc_r(2, 1, 7, SLT);
        imem[7]  = enc_r(1, 2, 8, SLT);
        imem[8]  = enc_r(1, 1, 0, ADD);
        imem[9]  = {6'b111111, 5'd1, 5'd3, 5'd3, 5'd0, 6'b100000};
        imem[10] = enc_i(SW, 0, 3, 32'h40);
        imem[11] = enc_i(SW, 0, 4, 32'h44);
        imem[12] = enc_i(SW, 0, 5, 32'h48);
        imem[13] = enc_i(SW, 0, 6, 32'h4C);
        imem[14] = enc_i(SW, 0, 7, 32'h50);
        imem[15] = enc_i(SW, 0, 8, 32'h54);
        imem[16] = enc_i(SW, 0, 0, 32'h58);
        imem[17] = enc_i(BEQ, 1, 2, 5);
        imem[18] = enc_i(BEQ, 1, 1, 3);
        imem[19] = enc_i(SW, 0, 1, 32'h5C);
        imem[20] = enc_i(SW, 0, 1, 32'h5C);
        imem[21] = enc_i(SW, 0, 1, 32'h5C);
        imem[22] = enc_i(LW, 0, 11, 8);
        imem[23] = enc_i(SW, 11, 1, -4);
        imem[24] = enc_i(BEQ, 0, 0, -1);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'h0, "R1 reset pc", {32'b0, imem_addr}, 64'h0);
        check(!dmem_we, "R1 no store in reset", {63'b0, dmem_we}, 64'h0);
        check(!trace_valid, "R9 trace low in reset", {63'b0, trace_valid}, 64'h0);

        // Driver: expected retirement order and store stream
        for (int i = 0; i <= 16; i++) push_trace(32'(i * 4), "R2 R9 sequence");
        push_trace(32'd68, "R6 not-taken branch");
        push_trace(32'd72, "R6 fall-through after not-taken");
        push_trace(32'd88, "R6 taken branch target");
        push_trace(32'd92, "R2 after branch");
        for (int i = 0; i < 9; i++) push_trace(32'd96, "R6 backward self-branch");

        push_store(32'h40, 32'd2,          "R3 R4 R8 add of loaded words, no-op kept r3");
        push_store(32'h44, 32'd8,          "R3 sub");
        push_store(32'h48, 32'd5,          "R3 and");
        push_store(32'h4C, 32'hFFFF_FFFD,  "R3 or");
        push_store(32'h50, 32'd1,          "R3 slt signed true");
        push_store(32'h54, 32'd0,          "R3 slt signed false");
        push_store(32'h58, 32'd0,          "R7 register zero after discarded write");
        push_store(32'hFC, 32'd5,          "R4 R5 negative offset store");

        @(posedge clk);
        #1 rst = 1'b0;
        running = 1'b1;

        while ((trace_q.size() != 0) && (cycles < WATCHDOG)) @(posedge clk);
        if (cycles >= WATCHDOG) begin
            check(1'b0, "watchdog expired", 64'(cycles), 64'(WATCHDOG));
        end
        @(negedge clk);
        check(store_q.size() == 0, "R5 R6 all expected stores seen",
              64'(store_q.size()), 64'd0);
        check(dmem[63] == 32'd5, "R5 store committed to memory", {32'b0, dmem[63]}, 64'd5);
        running = 1'b0;

        // R1: reset in the middle of a run
        @(posedge clk);
        #1 rst = 1'b1;
        @(negedge clk);
        check(!dmem_we && !trace_valid, "R1 R9 outputs quiet in mid-run reset",
              {62'b0, dmem_we, trace_valid}, 64'h0);
        @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'h0, "R1 pc back to zero", {32'b0, imem_addr}, 64'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule